// File: doc/BRIEF.md
# Distributed clock node timing unit

This block keeps the 64-bit nanosecond time base of one node on a distributed-clock fieldbus. Counting starts at an epoch fixed at the beginning of the year 2000. The local counter advances once per clock cycle. System time is the local time plus an offset that the host writes. Four per-port arrival latches catch the local time whenever a frame enters a port. The host loads the propagation delay and the offset. It reads the time values, the latched timestamps and the drift measurement through a 32-bit register port.

When a reference-time frame arrives, the block takes the received reference time and adds the stored delay. It subtracts that sum from its own system time at the receive instant and keeps the result in a readable register. It also feeds the result, clipped to 32 bits, into a first-order averaging filter. The averaged value sets the step of the counter. The step is 10 ns while the average stays within a small band around zero. If the node runs ahead of the reference the step is 9 ns, and if it lags the step is 11 ns. At most one stretched or shrunk tick is applied in any 16 ticks, which limits the slew.

Top module: `dc_time_unit`

## Requirements
- R1: After reset the local time, offset, delay, difference, filtered difference and all four port timestamps read as zero.
- R2: While the filtered difference is in the band -4..+4, the local time grows by exactly 10 on every clock cycle.
- R3: `sys_time_o` and the system-time register equal the local time plus the offset register (modulo 2^64). An offset write is visible from the cycle after the write.
- R4: A one-cycle pulse on `port_rx_i[p]` stores the local time of that cycle in the timestamp of port p. Pulses on several ports in the same cycle store the same value.
- R5: A pulse on `ref_valid_i` stores system time minus (`ref_time_i` plus delay), modulo 2^64, using the system time of that cycle. An offset write in the same cycle does not affect this sample.
- R6: Each reference sample updates the signed 32-bit filtered difference: filt := filt + floor((s - filt) / 16). Here s is the difference saturated to the signed 32-bit range.
- R7: A pace counter runs from 0 after reset and wraps every 16 cycles. Only on the tick where it equals 15 is the step 9 (filt > 4) or 11 (filt < -4). Every other tick steps 10.
- R8: Registers are 64-bit pairs at word addresses 2k (low) and 2k+1 (high). Reading a low word captures the matching high word. A read of the high word then returns that captured value.
- R9: The map is as follows. Pairs 0 to 5 are local time, system time, offset (read/write), delay (read/write), difference, and filtered difference sign-extended. Pairs 8 to 11 are the timestamps of ports 0 to 3. Every other address reads zero, and writes to read-only pairs change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one time tick per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (arms the high-word capture) |
| reg_addr_i | input | 5 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the current address |
| port_rx_i | input | 4 | Per-port frame-arrival pulses |
| ref_valid_i | input | 1 | Reference-time frame received |
| ref_time_i | input | 64 | Received reference time |
| sys_time_o | output | 64 | Current system time |

## Verification
Two collisions are provoked on purpose. First, an offset write is issued in the same cycle as a reference sample. The stored difference must then reflect the offset that applied before the write, while the system time must show the new offset one cycle later. Second, port arrival pulses land in the same cycle as a reference sample, and the timestamps are checked against the same local time the difference was built from. A cycle-accurate model in the bench judges both cases, along with every read across the slewing phases.

// File: rtl/dc_time_pkg.sv
package dc_time_pkg;
  localparam int TIME_W    = 64;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 5;
  localparam int NUM_PORTS = 4;
  localparam int STEP_W    = 8;
  localparam int PORT_PAIR = 8;

  typedef enum logic [3:0] {
    PAIR_LOCAL  = 4'd0,
    PAIR_SYS    = 4'd1,
    PAIR_OFFSET = 4'd2,
    PAIR_DELAY  = 4'd3,
    PAIR_DIFF   = 4'd4,
    PAIR_FILT   = 4'd5
  } pair_e;
endpackage

// File: rtl/dc_step_ctrl.sv
module dc_step_ctrl #(
  parameter int TIME_W     = 64,
  parameter int FILT_W     = 32,
  parameter int FILT_SHIFT = 4,
  parameter int PACE_W     = 4,
  parameter int DEAD_BAND  = 4,
  parameter int STEP_NOM   = 10,
  parameter int STEP_W     = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     smp_valid_i,
  input  logic [TIME_W-1:0]        smp_i,
  output logic signed [FILT_W-1:0] filt_o,
  output logic [STEP_W-1:0]        step_o
);
  localparam int EXT_W = TIME_W - FILT_W + 1;
  localparam logic signed [TIME_W-1:0] SAT_HI = {{EXT_W{1'b0}}, {(FILT_W-1){1'b1}}};
  localparam logic signed [TIME_W-1:0] SAT_LO = {{EXT_W{1'b1}}, {(FILT_W-1){1'b0}}};
  localparam logic signed [FILT_W-1:0] DB_P = FILT_W'(DEAD_BAND);
  localparam logic signed [FILT_W-1:0] DB_N = -DB_P;

  logic signed [FILT_W-1:0] filt_q, smp_sat;
  logic signed [FILT_W:0]   delta, delta_sh;
  logic [PACE_W-1:0]        pace_q;

  always_comb begin
    if ($signed(smp_i) > SAT_HI)      smp_sat = {1'b0, {(FILT_W-1){1'b1}}};
    else if ($signed(smp_i) < SAT_LO) smp_sat = {1'b1, {(FILT_W-1){1'b0}}};
    else                              smp_sat = smp_i[FILT_W-1:0];
    delta    = {smp_sat[FILT_W-1], smp_sat} - {filt_q[FILT_W-1], filt_q};
    delta_sh = delta >>> FILT_SHIFT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= '0;
      pace_q <= '0;
    end else begin
      pace_q <= pace_q + 1'b1;
      if (smp_valid_i) filt_q <= filt_q + delta_sh[FILT_W-1:0];
    end
  end

  // one adjusted tick per pace period bounds the slew
  always_comb begin
    step_o = STEP_W'(STEP_NOM);
    if (&pace_q) begin
      if (filt_q > DB_P)      step_o = STEP_W'(STEP_NOM - 1);
      else if (filt_q < DB_N) step_o = STEP_W'(STEP_NOM + 1);
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/dc_port_stamp.sv
module dc_port_stamp #(
  parameter int TIME_W    = 64,
  parameter int NUM_PORTS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_PORTS-1:0] rx_i,
  input  logic [TIME_W-1:0] local_i,
  output logic [TIME_W-1:0] stamp_o [NUM_PORTS]
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [TIME_W-1:0] stamp_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stamp_q <= '0;
      else if (rx_i[p]) stamp_q <= local_i;
    end
    assign stamp_o[p] = stamp_q;
  end
endmodule

// File: rtl/dc_reg_if.sv
module dc_reg_if
  import dc_time_pkg::*;
#(
  parameter int TIME_W    = 64,
  parameter int ADDR_W    = 5,
  parameter int NUM_PORTS = 4,
  parameter int FILT_W    = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic                     re_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [TIME_W/2-1:0]      wdata_i,
  output logic [TIME_W/2-1:0]      rdata_o,
  input  logic [TIME_W-1:0]        local_i,
  input  logic [TIME_W-1:0]        sys_i,
  input  logic [TIME_W-1:0]        diff_i,
  input  logic signed [FILT_W-1:0] filt_i,
  input  logic [TIME_W-1:0]        stamp_i [NUM_PORTS],
  output logic [TIME_W-1:0]        offset_o,
  output logic [TIME_W-1:0]        delay_o
);
  localparam int HALF   = TIME_W / 2;
  localparam int PAIR_W = ADDR_W - 1;

  logic [PAIR_W-1:0] pair;
  logic              hi_sel;
  logic [TIME_W-1:0] val, offset_q, delay_q;
  logic [HALF-1:0]   snap_q;

  assign pair   = addr_i[ADDR_W-1:1];
  assign hi_sel = addr_i[0];

  always_comb begin
    val = '0;
    case (pair)
      PAIR_W'(PAIR_LOCAL):  val = local_i;
      PAIR_W'(PAIR_SYS):    val = sys_i;
      PAIR_W'(PAIR_OFFSET): val = offset_q;
      PAIR_W'(PAIR_DELAY):  val = delay_q;
      PAIR_W'(PAIR_DIFF):   val = diff_i;
      PAIR_W'(PAIR_FILT):   val = {{(TIME_W-FILT_W){filt_i[FILT_W-1]}}, filt_i};
      default:              val = '0;
    endcase
    for (int p = 0; p < NUM_PORTS; p++)
      if (pair == PAIR_W'(PORT_PAIR + p)) val = stamp_i[p];
  end

  assign rdata_o = hi_sel ? snap_q : val[HALF-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q   <= '0;
      offset_q <= '0;
      delay_q  <= '0;
    end else begin
      if (re_i && !hi_sel) snap_q <= val[TIME_W-1:HALF];
      if (we_i && pair == PAIR_W'(PAIR_OFFSET)) begin
        if (hi_sel) offset_q[TIME_W-1:HALF] <= wdata_i;
        else        offset_q[HALF-1:0]      <= wdata_i;
      end
      if (we_i && pair == PAIR_W'(PAIR_DELAY)) begin
        if (hi_sel) delay_q[TIME_W-1:HALF] <= wdata_i;
        else        delay_q[HALF-1:0]      <= wdata_i;
      end
    end
  end

  assign offset_o = offset_q;
  assign delay_o  = delay_q;
endmodule

// File: rtl/dc_time_unit.sv
module dc_time_unit #(
  parameter int TIME_W     = 64,
  parameter int ADDR_W     = 5,
  parameter int NUM_PORTS  = 4,
  parameter int FILT_W     = 32,
  parameter int FILT_SHIFT = 4,
  parameter int PACE_W     = 4,
  parameter int DEAD_BAND  = 4,
  parameter int STEP_NOM   = 10,
  parameter int STEP_W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic                 reg_re_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [TIME_W/2-1:0]  reg_wdata_i,
  output logic [TIME_W/2-1:0]  reg_rdata_o,
  input  logic [NUM_PORTS-1:0] port_rx_i,
  input  logic                 ref_valid_i,
  input  logic [TIME_W-1:0]    ref_time_i,
  output logic [TIME_W-1:0]    sys_time_o
);
  logic [TIME_W-1:0]        local_q, diff_q, offset_q, delay_q, diff_now;
  logic [TIME_W-1:0]        stamp_q [NUM_PORTS];
  logic signed [FILT_W-1:0] filt;
  logic [STEP_W-1:0]        step;

  assign sys_time_o = local_q + offset_q;
  assign diff_now   = sys_time_o - (ref_time_i + delay_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      local_q <= '0;
      diff_q  <= '0;
    end else begin
      local_q <= local_q + TIME_W'(step);
      if (ref_valid_i) diff_q <= diff_now;
    end
  end

  dc_step_ctrl #(
    .TIME_W(TIME_W), .FILT_W(FILT_W), .FILT_SHIFT(FILT_SHIFT), .PACE_W(PACE_W),
    .DEAD_BAND(DEAD_BAND), .STEP_NOM(STEP_NOM), .STEP_W(STEP_W)
  ) u_step (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_valid_i(ref_valid_i), .smp_i(diff_now),
    .filt_o(filt), .step_o(step)
  );

  dc_port_stamp #(.TIME_W(TIME_W), .NUM_PORTS(NUM_PORTS)) u_stamp (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(port_rx_i), .local_i(local_q), .stamp_o(stamp_q)
  );

  dc_reg_if #(
    .TIME_W(TIME_W), .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .FILT_W(FILT_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .re_i(reg_re_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .local_i(local_q), .sys_i(sys_time_o), .diff_i(diff_q), .filt_i(filt),
    .stamp_i(stamp_q), .offset_o(offset_q), .delay_o(delay_q)
  );
endmodule

// File: rtl/dc_time_unit_chk.sv
module dc_time_unit_chk #(
  parameter int TIME_W = 64,
  parameter int ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              port_rx0_i,
  input logic              ref_valid_i,
  input logic [TIME_W-1:0] ref_time_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [TIME_W/2-1:0] reg_wdata_i,
  input logic [TIME_W-1:0] sys_time_o,
  input logic [TIME_W-1:0] local_q,
  input logic [TIME_W-1:0] delay_q,
  input logic [TIME_W-1:0] diff_q,
  input logic [TIME_W-1:0] stamp0_q
);
  logic [TIME_W-1:0] prev_local;
  logic              prev_ok;
  logic [4:0]        gap_q;
  logic [TIME_W-1:0] adv;
  logic              adj;

  assign adv = local_q - prev_local;
  assign adj = prev_ok && (adv != TIME_W'(10));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_local <= '0;
      prev_ok    <= 1'b0;
      gap_q      <= 5'd31;
    end else begin
      prev_local <= local_q;
      prev_ok    <= 1'b1;
      if (adj)               gap_q <= '0;
      else if (prev_ok && gap_q != 5'd31) gap_q <= gap_q + 1'b1;
    end
  end

  p_step_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prev_ok |-> (adv == TIME_W'(9) || adv == TIME_W'(10) || adv == TIME_W'(11)));

  p_pace_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj |-> gap_q >= 5'd15);

  p_offset_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_W'(4)) |=> ((sys_time_o - local_q) & 64'hFFFF_FFFF) == {32'd0, $past(reg_wdata_i)});

  p_stamp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_rx0_i |=> stamp0_q == $past(local_q));

  p_diff_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_valid_i |=> diff_q == $past(sys_time_o) - ($past(ref_time_i) + $past(delay_q)));
endmodule

bind dc_time_unit dc_time_unit_chk #(.TIME_W(TIME_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .port_rx0_i(port_rx_i[0]), .ref_valid_i(ref_valid_i),
  .ref_time_i(ref_time_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .sys_time_o(sys_time_o), .local_q(local_q),
  .delay_q(delay_q), .diff_q(diff_q), .stamp0_q(stamp_q[0])
);

// File: tb/dc_time_unit_bench.sv
module dc_time_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0, ref_v = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  rx = '0;
  logic [63:0] ref_t = '0;
  logic [31:0] rdata;
  logic [63:0] sys_t;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dc_time_unit u_dc_time_unit (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .port_rx_i(rx), .ref_valid_i(ref_v),
    .ref_time_i(ref_t), .sys_time_o(sys_t)
  );

  // reference model built from the requirements
  longint unsigned m_local, m_off, m_dly, m_diff;
  longint unsigned m_stamp [4];
  longint          m_filt;
  int              m_pace;
  logic [31:0]     m_snap;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_local = 0; m_off = 0; m_dly = 0; m_diff = 0; m_filt = 0; m_pace = 0;
      for (int p = 0; p < 4; p++) m_stamp[p] = 0;
    end else begin
      longint unsigned sysv;
      longint s;
      int step;
      sysv = m_local + m_off;
      step = 10;
      if (m_pace == 15 && m_filt > 4) step = 9;
      else if (m_pace == 15 && m_filt < -4) step = 11;
      if (ref_v) begin
        m_diff = sysv - (ref_t + m_dly);
        s = longint'(m_diff);
        if (s > 64'sd2147483647) s = 64'sd2147483647;
        else if (s < -64'sd2147483648) s = -64'sd2147483648;
        m_filt = m_filt + ((s - m_filt) >>> 4);
      end
      for (int p = 0; p < 4; p++) if (rx[p]) m_stamp[p] = m_local;
      if (we && addr == 5'd4) m_off[31:0] = wdata;
      if (we && addr == 5'd5) m_off[63:32] = wdata;
      if (we && addr == 5'd6) m_dly[31:0] = wdata;
      if (we && addr == 5'd7) m_dly[63:32] = wdata;
      m_local = m_local + longint'(step);
      m_pace = (m_pace + 1) % 16;
    end
  end

  function automatic longint unsigned pair_val(int pr);
    case (pr)
      0: return m_local;
      1: return m_local + m_off;
      2: return m_off;
      3: return m_dly;
      4: return m_diff;
      5: return longint'(m_filt);
      8, 9, 10, 11: return m_stamp[pr-8];
      default: return 0;
    endcase
  endfunction

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb [$];

  // driver: predicts, queues, then drives the read
  task automatic rd(input logic [4:0] a, input string tag);
    item_t it;
    longint unsigned v;
    v = pair_val(int'(a >> 1));
    if (!a[0]) begin it.exp = v[31:0]; m_snap = v[63:32]; end
    else it.exp = m_snap;
    it.tag = tag;
    sb.push_back(it);
    addr = a; re = 1'b1;
    @(posedge clk); #1 re = 1'b0;
  endtask

  task automatic rd64(input logic [4:0] a, input string tag);
    rd(a, tag); rd(a + 5'd1, tag);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [63:0] ref_for(input longint dv);
    return m_local + m_off - m_dly - longint'(dv);
  endfunction

  task automatic send_ref(input longint dv);
    ref_t = ref_for(dv); ref_v = 1'b1;
    @(posedge clk); #1 ref_v = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (re) begin
      item_t it;
      n_tests++;
      if (sb.size() == 0) begin
        n_fail++; $display("FAIL scoreboard empty: got %h expected none", rdata);
      end else begin
        it = sb.pop_front();
        if (rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s addr %0d: got %h expected %h", it.tag, addr, rdata, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    rd64(5'd4, "R1 offset"); rd64(5'd6, "R1 delay"); rd64(5'd8, "R1 diff");
    rd64(5'd10, "R1 filt");
    for (int p = 0; p < 4; p++) rd64(5'(16 + 2*p), "R1 stamp");
    // R2 nominal advance
    for (int i = 0; i < 20; i++) rd(5'd0, "R2 local");
    rd64(5'd0, "R8 local pair");
    // R3 offset
    wr(5'd4, 32'h8000_0123); wr(5'd5, 32'h0000_00A5);
    rd64(5'd2, "R3 sys"); rd64(5'd4, "R3 offset");
    if (sys_t !== m_local + m_off) begin
      n_fail++; $display("FAIL R3 sys_time_o: got %h expected %h", sys_t, m_local + m_off);
    end
    n_tests++;
    // R4 single and simultaneous stamps
    rx = 4'b0010; idle(1); rx = 4'b0000; idle(3);
    rd64(5'd18, "R4 port1");
    rx = 4'b1101; idle(1); rx = 4'b0000;
    for (int p = 0; p < 4; p++) rd64(5'(16 + 2*p), "R4 port");
    // R5/R6 with delay
    wr(5'd6, 32'd300); wr(5'd7, 32'd0);
    send_ref(3);
    rd64(5'd8, "R5 diff small"); rd64(5'd10, "R6 filt dead band");
    for (int i = 0; i < 18; i++) rd(5'd0, "R2 dead band");
    // R7 node ahead: shrink ticks
    send_ref(1000);
    rd64(5'd10, "R6 filt ahead");
    for (int i = 0; i < 40; i++) rd(5'd0, "R7 slow down");
    // R7 node behind: stretch ticks, R6 negative filter
    send_ref(-5000); send_ref(-5000); send_ref(-5000);
    rd64(5'd8, "R5 diff negative"); rd64(5'd10, "R6 filt behind");
    for (int i = 0; i < 40; i++) rd(5'd0, "R7 speed up");
    // R6 saturation
    send_ref(64'sh0000_0100_0000_0000);
    rd64(5'd10, "R6 saturate");
    // R5 collision: offset write + ref sample + port pulses in one cycle
    ref_t = ref_for(77); ref_v = 1'b1; rx = 4'b0101;
    addr = 5'd4; wdata = 32'h0000_1000; we = 1'b1;
    @(posedge clk); #1 ref_v = 1'b0; rx = 4'b0000; we = 1'b0;
    rd64(5'd8, "R5 diff old offset"); rd64(5'd2, "R3 sys new offset");
    rd64(5'd16, "R4 port0 same cycle"); rd64(5'd20, "R4 port2 same cycle");
    // R9 unmapped and read-only
    rd64(5'd12, "R9 unmapped"); rd64(5'd28, "R9 unmapped");
    wr(5'd0, 32'hFFFF_FFFF); wr(5'd8, 32'h1234_5678); wr(5'd20, 32'h5);
    rd64(5'd0, "R9 local untouched"); rd64(5'd8, "R9 diff untouched");
    rd64(5'd20, "R9 stamp untouched");
    // R8 hi without new lo returns last capture
    rd(5'd6, "R8 delay lo"); rd(5'd1, "R8 stale capture");
    idle(2);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule